// File: doc/BRIEF.md
# Per-Port PWM and Blink Waveform Generator

This block computes the logic level of up to four output ports from one shared timing clock. The timing clock is supplied as a single-cycle enable pulse, `tick`, at the oscillator rate. Each port has a one-byte control word. That word either holds the port at a fixed level, or selects one of two waveforms. The first is a 32-slot PWM intensity pattern, which has a 5-bit duty. The second is a slow blink pattern, which has a 4-bit duty.

All ports share one 5-bit PWM counter. Each port compares this counter against its own phase offset, so the ports switch on different ticks. A divider turns ticks into 16 blink slots per blink period. A 3-bit select sets the slot length. A counter restart happens only when a restart request arrives and the restart enable is also set. It clears every counter, so several instances can be brought back into step.

Together, the fixed levels and the 32 duty codes give 33 intensity steps: always low, 1/32 through 31/32, and always high.

Top module: `led_wave_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output reads 0 after that edge. Reset also clears all counters, so the first sample after release reflects a PWM count of 0 and blink slot 0.
- R2: The PWM counter and the blink divider advance by one only on a clock edge at which `tick` is 1. The PWM counter wraps after 32 ticks. Clock edges without `tick` leave every output unchanged.
- R3: In PWM mode (control bit 5 = 0), bits 4:0 hold a duty code n. The port is 1 on n of the 32 PWM counts and 0 on the rest. Code 0 keeps the port always 0.
- R4: Port p uses the phase (count − 8·p) mod 32 and is 1 while that phase is below n. Port p's high window therefore starts 8·p counts after port 0's.
- R5: In blink mode (control bit 5 = 1), bits 4:1 hold a code m, and bit 0 is ignored. The port is 1 while the 4-bit blink slot is below m, giving m/16 of the period. Code 0 keeps the port always 0.
- R6: One blink slot lasts 2^(SLOT_LOG2+s) ticks, where s is the `blink_sel` value. Select 7 behaves exactly like select 6. The blink slot advances only when the divider wraps.
- R7: When control bit 7 is 1, the port drives control bit 6 and ignores the mode and duty fields.
- R8: `timer_rst_req` and `timer_rst_en` both high at an edge clear the PWM counter, the divider and the blink slot, even if `tick` is also high at that edge. A request without the enable has no effect.
- R9: Outputs are registered. A change of counter state or of a control byte appears on `port_out` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timing-clock enable, one cycle wide per oscillator period |
| port_ctrl | input | NPORTS*8 | Control byte per port, port p at bits 8p+7:8p (bit 7 hold enable, bit 6 hold level, bit 5 mode, bits 4:0 duty) |
| blink_sel | input | SEL_W | Blink slot length select |
| timer_rst_en | input | 1 | Allows a restart request to clear the counters |
| timer_rst_req | input | 1 | Counter restart request |
| port_out | output | NPORTS | Output level per port |

## Verification
A tick updates the counters at the edge where it is high, and the output register follows at the next edge. Each output therefore settles two edges after a tick is driven. The bench pulses `tick` for one cycle, waits one further edge, and samples at the falling edge after that. A restart request follows the same two-edge path.

A control-byte change reaches the output after a single edge. The bench checks this by sampling just before and just after that edge. Between ticks, expected levels come from a tick count kept by the bench, with `blink_sel` held constant since the last restart.

// File: rtl/lwg_pkg.sv
`timescale 1ns/1ps
// Shared types for the PWM/blink waveform generator.
// Assumes an 8-bit control word per port with a 5-bit duty field.
package lwg_pkg;
    localparam int DUTY_W  = 5;
    localparam int CTRL_W  = 8;
    localparam int BLINK_W = 4;

    typedef enum logic {
        WAVE_PWM   = 1'b0,
        WAVE_BLINK = 1'b1
    } wave_mode_e;

    typedef struct packed {
        logic              hold_en;
        logic              hold_lvl;
        wave_mode_e        mode;
        logic [DUTY_W-1:0] duty;
    } port_ctrl_t;
endpackage

// File: rtl/lwg_timebase.sv
`timescale 1ns/1ps
// Shared timebase: a 5-bit PWM counter, plus a blink divider feeding a
// 4-bit blink slot counter. Everything advances only on tick.
// Assumes restart is already qualified by its enable; restart wins over tick.
module lwg_timebase
    import lwg_pkg::*;
#(
    parameter int SLOT_LOG2 = 8,
    parameter int SEL_W     = 3,
    parameter int SEL_MAX   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               restart,
    input  logic [SEL_W-1:0]   blink_sel,
    output logic [DUTY_W-1:0]  pwm_cnt,
    output logic [BLINK_W-1:0] blink_slot
);
    localparam int DIV_W = SLOT_LOG2 + SEL_MAX;

    logic [SEL_W-1:0] sel_eff;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] div_limit;
    logic [DIV_W-1:0] div_cnt;
    logic             slot_wrap;

    // Clamp the select, then derive the last divider value of one slot.
    always_comb begin
        sel_eff   = (int'(blink_sel) > SEL_MAX) ? SEL_W'(SEL_MAX) : blink_sel;
        span      = (DIV_W+1)'(1) << (SLOT_LOG2 + int'(sel_eff));
        div_limit = DIV_W'(span - 1'b1);
        slot_wrap = (div_cnt >= div_limit);
    end

    // PWM counter: free-running modulo 32 on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pwm_cnt <= '0;
        end else if (tick) begin
            pwm_cnt <= pwm_cnt + 1'b1;
        end
    end

    // Blink divider and slot counter: the slot steps when the divider wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_cnt    <= '0;
            blink_slot <= '0;
        end else if (tick) begin
            if (slot_wrap) begin
                div_cnt    <= '0;
                blink_slot <= blink_slot + 1'b1;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> ($stable(pwm_cnt) && $stable(blink_slot)));

    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pwm_cnt == '0 && blink_slot == '0 && div_cnt == '0));

    assert_slot_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && (div_cnt < div_limit)) |=> $stable(blink_slot));
endmodule

// File: rtl/lwg_port_wave.sv
`timescale 1ns/1ps
// One port's waveform: a phase-shifted PWM compare, a blink compare and
// the hold override, followed by a registered output.
// Assumes PHASE_OFS is already reduced modulo 32.
module lwg_port_wave
    import lwg_pkg::*;
#(
    parameter int PHASE_OFS = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  port_ctrl_t         ctrl,
    input  logic [DUTY_W-1:0]  pwm_cnt,
    input  logic [BLINK_W-1:0] blink_slot,
    output logic               wave_out
);
    logic [DUTY_W-1:0] phase;
    logic              pwm_on;
    logic              blink_on;
    logic              level_nxt;

    // Select the next level: hold override first, then the chosen waveform.
    always_comb begin
        phase    = pwm_cnt - DUTY_W'(PHASE_OFS);
        pwm_on   = (phase < ctrl.duty);
        blink_on = (blink_slot < ctrl.duty[DUTY_W-1:1]);
        if (ctrl.hold_en) begin
            level_nxt = ctrl.hold_lvl;
        end else if (ctrl.mode == WAVE_BLINK) begin
            level_nxt = blink_on;
        end else begin
            level_nxt = pwm_on;
        end
    end

    // Output register, so the port never glitches between compares.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_out <= 1'b0;
        end else begin
            wave_out <= level_nxt;
        end
    end

    assert_pwm_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.hold_en && ctrl.mode == WAVE_PWM && ctrl.duty == '0) |=> !wave_out);

    assert_blink_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.hold_en && ctrl.mode == WAVE_BLINK && ctrl.duty[DUTY_W-1:1] == '0) |=> !wave_out);

    assert_hold_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.hold_en |=> (wave_out == $past(ctrl.hold_lvl)));
endmodule

// File: rtl/led_wave_gen.sv
`timescale 1ns/1ps
// Top of the per-port PWM/blink generator. It holds one shared timebase
// and NPORTS port waveform units, each with a phase offset of
// port index times STAGGER.
// Assumes tick is a one-cycle enable at the oscillator rate.
module led_wave_gen
    import lwg_pkg::*;
#(
    parameter int NPORTS    = 4,
    parameter int STAGGER   = 8,
    parameter int SLOT_LOG2 = 8,
    parameter int SEL_W     = 3,
    parameter int SEL_MAX   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [NPORTS*CTRL_W-1:0] port_ctrl,
    input  logic [SEL_W-1:0]         blink_sel,
    input  logic                     timer_rst_en,
    input  logic                     timer_rst_req,
    output logic [NPORTS-1:0]        port_out
);
    localparam int PWM_SLOTS = 1 << DUTY_W;

    logic               restart;
    logic [DUTY_W-1:0]  pwm_cnt;
    logic [BLINK_W-1:0] blink_slot;

    // A restart request counts only when the restart option is enabled.
    always_comb restart = timer_rst_en & timer_rst_req;

    lwg_timebase #(
        .SLOT_LOG2 (SLOT_LOG2),
        .SEL_W     (SEL_W),
        .SEL_MAX   (SEL_MAX)
    ) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .restart    (restart),
        .blink_sel  (blink_sel),
        .pwm_cnt    (pwm_cnt),
        .blink_slot (blink_slot)
    );

    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_port
        localparam int OFS = (gi * STAGGER) % PWM_SLOTS;
        lwg_port_wave #(
            .PHASE_OFS (OFS)
        ) u_wave (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl       (port_ctrl_t'(port_ctrl[gi*CTRL_W +: CTRL_W])),
            .pwm_cnt    (pwm_cnt),
            .blink_slot (blink_slot),
            .wave_out   (port_out[gi])
        );
    end

    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (port_out == '0));
endmodule

// File: tb/led_wave_gen_tb_top.sv
`timescale 1ns/1ps
module led_wave_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [31:0] port_ctrl = '0;
    logic [2:0]  blink_sel = '0;
    logic        timer_rst_en = 1'b0;
    logic        timer_rst_req = 1'b0;
    logic [3:0]  port_out;

    int n_checks = 0;
    int n_errs = 0;
    int nticks = 0;

    always #2.5 clk = ~clk;

    led_wave_gen #(.NPORTS(4), .STAGGER(8), .SLOT_LOG2(2), .SEL_W(3), .SEL_MAX(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .port_ctrl(port_ctrl),
        .blink_sel(blink_sel), .timer_rst_en(timer_rst_en),
        .timer_rst_req(timer_rst_req), .port_out(port_out)
    );

    // Expected level from the requirements, given ticks since restart.
    function automatic bit model(logic [7:0] c, int p, int n, int sel);
        int s;
        int cnt;
        int slot;
        s    = (sel > 6) ? 6 : sel;
        cnt  = n % 32;
        slot = (n >> (2 + s)) % 16;
        if (c[7]) return c[6];
        if (c[5]) return (slot < int'(c[4:1]));
        return (((cnt - 8*p) & 31) < int'(c[4:0]));
    endfunction

    task automatic check_bit(bit got, bit exp, string req, string what);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, got, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int p = 0; p < 4; p++)
            check_bit(port_out[p], model(port_ctrl[p*8 +: 8], p, nticks, int'(blink_sel)),
                      req, $sformatf("port%0d tick%0d", p, nticks));
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        @(negedge clk);
        nticks++;
    endtask

    task automatic do_clear();
        @(negedge clk) begin timer_rst_en = 1'b1; timer_rst_req = 1'b1; end
        @(negedge clk) begin timer_rst_en = 1'b0; timer_rst_req = 1'b0; end
        @(negedge clk);
        nticks = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errs++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        // R1: reset state, then the first sample after release.
        for (int p = 0; p < 4; p++) port_ctrl[p*8 +: 8] = 8'h05;
        repeat (3) @(negedge clk);
        for (int p = 0; p < 4; p++) check_bit(port_out[p], 1'b0, "R1", "in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R3 R4 R2: PWM sweep over all 32 duty codes, all phases.
        for (int r = 0; r < 8; r++) begin
            for (int p = 0; p < 4; p++) port_ctrl[p*8 +: 8] = 8'((r*4 + p) & 31);
            do_clear();
            check_all("R3");
            for (int t = 0; t < 33; t++) begin
                do_tick();
                check_all("R4");
            end
        end
        // R2: idle cycles without tick keep outputs.
        for (int p = 0; p < 4; p++) port_ctrl[p*8 +: 8] = 8'd12;
        do_clear();
        repeat (5) do_tick();
        repeat (7) @(negedge clk);
        check_all("R2");

        // R5 R6: blink sweep at select 0, bit 0 toggled to show it is ignored.
        blink_sel = 3'd0;
        for (int r = 0; r < 4; r++) begin
            for (int p = 0; p < 4; p++)
                port_ctrl[p*8 +: 8] = {3'b001, 4'((r*4 + p) & 15), 1'(p & 1)};
            do_clear();
            check_all("R5");
            for (int t = 0; t < 64; t++) begin
                do_tick();
                check_all("R5");
            end
        end

        // R6: select 3 and select 7 (behaves as 6) slot lengths.
        for (int p = 0; p < 4; p++) port_ctrl[p*8 +: 8] = {3'b001, 4'(p + 1), 1'b0};
        blink_sel = 3'd3;
        do_clear();
        for (int t = 0; t < 70; t++) begin
            do_tick();
            check_all("R6");
        end
        blink_sel = 3'd7;
        do_clear();
        for (int t = 0; t < 260; t++) begin
            do_tick();
            if (t >= 250) check_all("R6");
        end
        check_bit(port_out[0], 1'b0, "R6", "sel7 slot1 port0");
        check_bit(port_out[1], 1'b1, "R6", "sel7 slot1 port1");

        // R7: hold override in both modes and both levels.
        blink_sel = 3'd0;
        port_ctrl = {8'h80, 8'hE0, 8'hDF, 8'hC0};
        do_clear();
        for (int t = 0; t < 20; t++) begin
            do_tick();
            check_all("R7");
        end

        // R8: request without enable ignored; enable wins over tick.
        for (int p = 0; p < 4; p++) port_ctrl[p*8 +: 8] = 8'd3;
        do_clear();
        repeat (10) do_tick();
        @(negedge clk) timer_rst_req = 1'b1;
        @(negedge clk) timer_rst_req = 1'b0;
        @(negedge clk);
        check_all("R8");
        check_bit(port_out[1], 1'b1, "R8", "no-enable request kept count");
        @(negedge clk) begin timer_rst_en = 1'b1; timer_rst_req = 1'b1; tick = 1'b1; end
        @(negedge clk) begin timer_rst_en = 1'b0; timer_rst_req = 1'b0; tick = 1'b0; end
        @(negedge clk);
        nticks = 0;
        check_all("R8");
        check_bit(port_out[0], 1'b1, "R8", "restart beat tick");

        // R9: control change seen exactly one edge later.
        port_ctrl[7:0] = 8'h00;
        @(negedge clk);
        @(negedge clk);
        check_bit(port_out[0], 1'b0, "R9", "before change");
        port_ctrl[7:0] = 8'hC0;
        #1;
        check_bit(port_out[0], 1'b0, "R9", "before edge");
        @(negedge clk);
        check_bit(port_out[0], 1'b1, "R9", "after edge");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule